// File: doc/BRIEF.md
# Dithered Four-Quadrant H-Bridge PWM Generator

This block turns a signed, high-resolution duty command into the four gate signals of a full H-bridge. A free-running counter defines a PWM period of 2^CNT_W clock cycles. Each bridge leg switches high for a computed number of counts per period. The averaged voltage across the load follows the difference between the two legs' on-times, so the command reaches all four quadrants. A zero command places both legs at the half-period point.

The resolution is built in three layers. The coarse field moves the two legs apart symmetrically, which gives two counts of difference per step. The offset bit adds one count to leg A alone and leaves leg B where it is. The two fraction bits add one more count to leg A in a fixed subset of a repeating group of four periods, which gives a quarter count on average. Together these layers reach the fine resolution needed to keep the smallest output step below the smallest step of the current reading, so the control loop does not limit-cycle. Commands are held back until the next four-period group begins. Each leg drives a complementary high/low pair with dead time inserted at every transition. A one-cycle marker flags the start of every period so that sampling can be aligned to it.

Top module: `hbd_bridge_pwm`

## Requirements
- R1: While reset is high, all four gate outputs and the period marker are low. After reset the applied command is zero.
- R2: `period_start` is high for exactly one cycle in every 2^CNT_W cycles. The first pulse is the first cycle after reset is released.
- R3: The command layout is: bits [CNT_W+2:3] = signed coarse value c, bit 2 = offset bit o, bits [1:0] = fraction f. Leg A on-time per period is T_A = 2^(CNT_W-1) + c + o + d, and leg B on-time is T_B = 2^(CNT_W-1) - c. Here d is the dither count for the current slot.
- R4: The slot is the period index since reset, modulo 4. The dither count d is 1 in these slots: slot 0 for f=1; slots 0 and 2 for f=2; slots 0, 1 and 2 for f=3. It is 0 in all other cases.
- R5: The offset bit raises leg A's on-time by exactly one count in every slot and does not change leg B.
- R6: On-times are clamped to the range 0 to 2^CNT_W. A leg whose clamped on-time is 2^CNT_W stays on for the whole period.
- R7: A command accepted with `cmd_valid` takes effect from the first period of the next four-period group. If several commands arrive within one group, the last one is applied.
- R8: The high side and the low side of a leg are never on together. After any change of the leg's raw state, both stay off for DEAD cycles. In a period that starts low and has 0 < T < 2^CNT_W, the high side is on for max(0, T-DEAD) cycles and the low side for max(0, 2^CNT_W-T-DEAD) cycles.
- R9: A leg whose on-time is 0 or full across consecutive periods stays in one state, with no dead-time gap at the period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Accepts `cmd_word` this cycle |
| cmd_word | input | CNT_W+3 | Signed duty command (coarse, offset, fraction) |
| leg_a_hi | output | 1 | Leg A high-side gate |
| leg_a_lo | output | 1 | Leg A low-side gate |
| leg_b_hi | output | 1 | Leg B high-side gate |
| leg_b_lo | output | 1 | Leg B low-side gate |
| period_start | output | 1 | One-cycle marker at each period start |

## Verification
Each command is scored period by period. For every slot, the bench counts high-side and low-side cycles on both legs and compares them with on-times predicted from the command. Commands with only a coarse value check the symmetric leg split. Adding the offset bit shows that leg B does not move. Each fraction value (1, 2, 3) checks which slots gain a count. Extreme coarse values drive the clamp and the steady full-on and full-off states, where no dead-time gap may appear. Two commands sent within one group show that only the later one is applied, and only at the group boundary.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    typedef enum logic [1:0] {
        LEG_A = 2'd0,
        LEG_B = 2'd1
    } leg_e;

    // Extra count for leg A in a given slot of the four-period group
    function automatic logic dither_hit(input logic [1:0] frac, input logic [1:0] slot);
        logic hit;
        case (frac)
            2'd1:    hit = (slot == 2'd0);
            2'd2:    hit = (slot[0] == 1'b0);
            2'd3:    hit = (slot != 2'd3);
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

    // Keep an on-time inside the period
    function automatic int clamp_span(input int value, input int full);
        int r;
        if (value < 0)
            r = 0;
        else if (value > full)
            r = full;
        else
            r = value;
        return r;
    endfunction

endpackage

// File: rtl/hbd_timebase.sv
module hbd_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_q,
    output logic [1:0]       slot_q,
    output logic             seq_end,
    output logic             pstart_q
);
    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    logic period_end;

    assign period_end = (cnt_q == CNT_LAST);
    assign seq_end    = period_end && (slot_q == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            slot_q   <= 2'd0;
            pstart_q <= 1'b0;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
            pstart_q <= (cnt_q == '0);
            if (period_end)
                slot_q <= slot_q + 2'd1;
        end
    end
endmodule

// File: rtl/hbd_cmd_stage.sv
module hbd_cmd_stage
    import hbd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [CNT_W+2:0] cmd_word,
    input  logic             seq_end,
    input  logic [1:0]       slot,
    output logic [CNT_W+2:0] act_cmd,
    output logic [CNT_W:0]   on_a,
    output logic [CNT_W:0]   on_b
);
    localparam int FULL = 2 ** CNT_W;
    localparam int HALF = FULL / 2;

    logic [CNT_W+2:0]        pend_q;
    logic                    pend_v;
    logic signed [CNT_W-1:0] coarse;
    logic                    offs;
    logic [1:0]              frac;
    logic                    dith;
    int                      sum_a;
    int                      sum_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            pend_v  <= 1'b0;
            act_cmd <= '0;
        end else if (seq_end) begin
            if (cmd_valid)
                act_cmd <= cmd_word;
            else if (pend_v)
                act_cmd <= pend_q;
            pend_v <= 1'b0;
        end else if (cmd_valid) begin
            pend_q <= cmd_word;
            pend_v <= 1'b1;
        end
    end

    assign coarse = act_cmd[CNT_W+2:3];
    assign offs   = act_cmd[2];
    assign frac   = act_cmd[1:0];
    assign dith   = dither_hit(frac, slot);

    always_comb begin
        sum_a = HALF + int'(coarse) + int'(offs) + int'(dith);
        sum_b = HALF - int'(coarse);
        on_a  = (CNT_W+1)'(clamp_span(sum_a, FULL));
        on_b  = (CNT_W+1)'(clamp_span(sum_b, FULL));
    end
endmodule

// File: rtl/hbd_leg_gate.sv
module hbd_leg_gate
    import hbd_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DEAD  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W:0]   on_time,
    output gate_pair_t       gate
);
    localparam int DW = (DEAD < 1) ? 1 : $clog2(DEAD + 1);
    localparam logic [DW-1:0] DEAD_LD = DW'(DEAD);

    logic          raw;
    logic          state_q;
    logic [DW-1:0] dcnt_q;
    logic          settled;

    assign raw     = ({1'b0, cnt} < on_time);
    assign settled = (dcnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= 1'b0;
            dcnt_q  <= DEAD_LD;
        end else if (raw != state_q) begin
            state_q <= raw;
            dcnt_q  <= DEAD_LD;
        end else if (!settled) begin
            dcnt_q <= dcnt_q - 1'b1;
        end
    end

    assign gate.hi = state_q && settled;
    assign gate.lo = !state_q && settled;
endmodule

// File: rtl/hbd_bridge_pwm.sv
module hbd_bridge_pwm
    import hbd_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DEAD  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [CNT_W+2:0] cmd_word,
    output logic             leg_a_hi,
    output logic             leg_a_lo,
    output logic             leg_b_hi,
    output logic             leg_b_lo,
    output logic             period_start
);
    localparam int NLEG = 2;

    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       slot_q;
    logic             seq_end;
    logic [CNT_W+2:0] act_cmd;
    logic [CNT_W:0]   on_a;
    logic [CNT_W:0]   on_b;
    logic [CNT_W:0]   on_leg [NLEG];
    gate_pair_t       gates  [NLEG];

    hbd_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .cnt_q    (cnt_q),
        .slot_q   (slot_q),
        .seq_end  (seq_end),
        .pstart_q (period_start)
    );

    hbd_cmd_stage #(.CNT_W(CNT_W)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .seq_end   (seq_end),
        .slot      (slot_q),
        .act_cmd   (act_cmd),
        .on_a      (on_a),
        .on_b      (on_b)
    );

    assign on_leg[LEG_A] = on_a;
    assign on_leg[LEG_B] = on_b;

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        hbd_leg_gate #(.CNT_W(CNT_W), .DEAD(DEAD)) u_leg (
            .clk     (clk),
            .rst     (rst),
            .cnt     (cnt_q),
            .on_time (on_leg[g]),
            .gate    (gates[g])
        );
    end

    assign leg_a_hi = gates[LEG_A].hi;
    assign leg_a_lo = gates[LEG_A].lo;
    assign leg_b_hi = gates[LEG_B].hi;
    assign leg_b_lo = gates[LEG_B].lo;
endmodule

// File: rtl/hbd_bridge_chk.sv
module hbd_bridge_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             a_hi,
    input logic             a_lo,
    input logic             b_hi,
    input logic             b_lo,
    input logic             pstart,
    input logic [CNT_W-1:0] cnt_q,
    input logic [1:0]       slot_q,
    input logic [CNT_W+2:0] act_cmd
);
    // R8: no shoot-through on either leg
    a_r8_no_overlap_a: assert property (@(posedge clk) disable iff (rst) !(a_hi && a_lo));
    a_r8_no_overlap_b: assert property (@(posedge clk) disable iff (rst) !(b_hi && b_lo));

    // R8: a side only switches on after the other side was already off
    a_r8_gap_a: assert property (@(posedge clk) disable iff (rst) $rose(a_lo) |-> $past(!a_hi));
    a_r8_gap_b: assert property (@(posedge clk) disable iff (rst) $rose(b_hi) |-> $past(!b_lo));

    // R2: marker lasts one cycle and coincides with the counter having just left zero
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst) pstart |=> !pstart);
    a_r2_marker_phase: assert property (@(posedge clk) disable iff (rst) pstart |-> (cnt_q == 1));

    // R7: applied command only changes as a new four-period group begins
    a_r7_group_edge: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_cmd) |-> (cnt_q == '0 && slot_q == 2'd0));
endmodule

bind hbd_bridge_pwm hbd_bridge_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_hi    (leg_a_hi),
    .a_lo    (leg_a_lo),
    .b_hi    (leg_b_hi),
    .b_lo    (leg_b_lo),
    .pstart  (period_start),
    .cnt_q   (cnt_q),
    .slot_q  (slot_q),
    .act_cmd (act_cmd)
);

// File: tb/tb_hbd_bridge_pwm.sv
module tb_hbd_bridge_pwm;
    localparam int CLK_PERIOD = 10;
    localparam int CW   = 5;
    localparam int DT   = 2;
    localparam int P    = 2 ** CW;
    localparam int HALF = P / 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [CW+2:0] cmd_word = '0;
    logic          leg_a_hi, leg_a_lo, leg_b_hi, leg_b_lo, period_start;

    hbd_bridge_pwm #(.CNT_W(CW), .DEAD(DT)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .leg_a_hi(leg_a_hi), .leg_a_lo(leg_a_lo), .leg_b_hi(leg_b_hi),
        .leg_b_lo(leg_b_lo), .period_start(period_start)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int    idx;
        int    ahs, als, bhs, bls;
        string tag;
    } item_t;

    item_t q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    int    pidx   = -1;
    int    wl, c_ahs, c_als, c_bhs, c_bls;
    int    prev_a = 0;
    int    prev_b = 0;
    int    last_seq = -100;
    bit    done = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int dith(input int f, input int s);
        return ((f == 1 && s == 0) || (f == 2 && (s == 0 || s == 2)) || (f == 3 && s != 3)) ? 1 : 0;
    endfunction

    function automatic int clampv(input int v);
        return (v < 0) ? 0 : ((v > P) ? P : v);
    endfunction

    function automatic int exp_hi(input int t, input int pt);
        if (t == 0) return 0;
        if (pt == P) return t;
        return (t > DT) ? t - DT : 0;
    endfunction

    function automatic int exp_lo(input int t, input int pt);
        if (t == P) return 0;
        if (t == 0) return (pt == P) ? P - DT : P;
        return (P - t > DT) ? P - t - DT : 0;
    endfunction

    // Driver side: expected items for four periods of one command
    task automatic push_group(input int base, input int c, input int o, input int f, input string tag);
        for (int s = 0; s < 4; s++) begin
            item_t it;
            int ta, tb;
            ta = clampv(HALF + c + o + dith(f, s));
            tb = clampv(HALF - c);
            it.idx = base + s;
            it.ahs = exp_hi(ta, prev_a);
            it.als = exp_lo(ta, prev_a);
            it.bhs = exp_hi(tb, prev_b);
            it.bls = exp_lo(tb, prev_b);
            it.tag = tag;
            q.push_back(it);
            prev_a = ta;
            prev_b = tb;
        end
    endtask

    // Monitor side: gather a period, compare with the queue head
    task automatic close_window(input int k);
        check("R2 period length", wl, P);
        if (q.size() == 0) return;
        if (q[0].idx < k) begin
            n_fail++;
            $display("FAIL %s: item for period %0d missed, now %0d", q[0].tag, q[0].idx, k);
            void'(q.pop_front());
            return;
        end
        if (q[0].idx == k) begin
            item_t it;
            it = q.pop_front();
            check({it.tag, " leg A high"}, c_ahs, it.ahs);
            check({it.tag, " leg A low"},  c_als, it.als);
            check({it.tag, " leg B high"}, c_bhs, it.bhs);
            check({it.tag, " leg B low"},  c_bls, it.bls);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (period_start) begin
                if (pidx >= 0) close_window(pidx);
                pidx++;
                wl = 0; c_ahs = 0; c_als = 0; c_bhs = 0; c_bls = 0;
            end
            if (pidx >= 0) begin
                wl++;
                c_ahs += int'(leg_a_hi);
                c_als += int'(leg_a_lo);
                c_bhs += int'(leg_b_hi);
                c_bls += int'(leg_b_lo);
            end
        end
    end

    task automatic wait_group();
        do begin
            @(negedge clk);
            #1;
        end while (!(period_start && (pidx % 4) == 0 && pidx != last_seq));
        last_seq = pidx;
    endtask

    function automatic logic [CW+2:0] mk(input int c, input int o, input int f);
        return {CW'(c), 1'(o), 2'(f)};
    endfunction

    task automatic send(input int c, input int o, input int f);
        cmd_word  = mk(c, o, f);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_cmd(input int c, input int o, input int f, input string tag);
        int base;
        wait_group();
        base = pidx + 4;
        send(c, o, f);
        push_group(base, c, o, f, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) begin
            @(negedge clk);
            check("R1 reset leg A high", int'(leg_a_hi), 0);
            check("R1 reset leg A low",  int'(leg_a_lo), 0);
            check("R1 reset leg B high", int'(leg_b_hi), 0);
            check("R1 reset leg B low",  int'(leg_b_lo), 0);
            check("R1 reset marker",     int'(period_start), 0);
        end
        rst = 1'b0;
        push_group(0, 0, 0, 0, "R1 zero after reset");

        run_cmd(3, 0, 0,   "R3 coarse only");
        run_cmd(3, 1, 0,   "R5 offset bit");
        run_cmd(-5, 0, 1,  "R4 fraction 1");
        run_cmd(0, 0, 2,   "R4 fraction 2");
        run_cmd(2, 1, 3,   "R4 fraction 3");
        run_cmd(15, 1, 3,  "R6 clamp full");
        run_cmd(15, 1, 0,  "R9 steady full");
        run_cmd(-16, 0, 0, "R9 full to empty");

        // R7: two commands in one group, only the later one applies
        begin
            int base;
            wait_group();
            base = pidx + 4;
            send(7, 0, 0);
            repeat (40) @(negedge clk);
            send(-2, 0, 1);
            push_group(base, -2, 0, 1, "R7 last command wins");
        end

        run_cmd(0, 0, 0, "R8 back to zero");
        wait_group();
        wait_group();
        wait_group();
        check("R7 all items consumed", q.size(), 0);
        finish_run();
    end
endmodule